// File: doc/BRIEF.md
# Two-Key Watchdog Timer

This block is a watchdog counter for a small processor. Software keeps it from firing by issuing two different clear commands, each a one-cycle pulse. In the default mode the counter restarts only when one command is followed by the other. Sending the same command twice in a row does nothing, so a runaway loop that keeps hitting one clear instruction cannot keep the watchdog quiet. A configuration input can relax this so that either command clears the counter on its own.

The block counts clock cycles. A select input chooses a time-out period of 2^(BASE_LOG+n) cycles. When the count runs out during normal running, the block raises a one-cycle reset request. When it runs out while the processor is halted in power-down, the block raises a one-cycle wake request instead and leaves power-down.

The block keeps two status flags. The time-out flag records that the watchdog fired. The power-down flag records that a halt command was taken. A completed clear drops both flags. A halt sets the power-down flag and clears the time-out flag.

Top module: `wdt_two_key`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, the key history and the power-down state are cleared. After that edge, `to_flag`, `pd_flag`, `wdt_reset` and `wake_req` are all 0.
- R2: With `tap_sel` = n held stable, the time-out output rises exactly 2^(BASE_LOG+n) clock edges after the edge that restarted the count. That restart can be a reset, a completed clear, a halt or the previous time-out. The output pulse lasts one cycle.
- R3: In pair mode (`single_clr_en` = 0), a `clr_key_a` pulse followed later by a `clr_key_b` pulse, or B followed by A, completes a clear. No other key pulse may come between them. A completed clear restarts the count at the edge of the second key and sets `to_flag` and `pd_flag` to 0.
- R4: In pair mode, a key pulse repeated with no pulse of the other key between them has no effect. The count is not restarted and the flags keep their values. The pair is then completed by the next pulse of the other key.
- R5: With `single_clr_en` = 1, a pulse on either key alone completes a clear.
- R6: A `halt_cmd` pulse restarts the count, sets `pd_flag` to 1, sets `to_flag` to 0, forgets any half-entered key pair and enters power-down.
- R7: A time-out while not in power-down gives a one-cycle `wdt_reset` pulse and no `wake_req`. It sets `to_flag` to 1, leaves `pd_flag` unchanged, forgets any half-entered key pair and restarts the count.
- R8: A time-out in power-down gives a one-cycle `wake_req` pulse and no `wdt_reset`. It sets `to_flag` to 1, keeps `pd_flag` at 1 and leaves power-down, so the next time-out is a `wdt_reset`.
- R9: Key pulses received while in power-down are ignored. They neither restart the count nor arm half of a pair.
- R10: When events coincide on one edge, a halt wins over a clear, and a clear wins over a time-out, so a clear landing on the expiry edge produces no pulse. Both keys pulsed on the same edge complete a clear in pair mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock; the counter advances on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tap_sel | input | TSW | Period select n, period 2^(BASE_LOG+n) cycles; hold stable while running |
| single_clr_en | input | 1 | 1 lets either key clear alone; 0 requires the alternating pair |
| clr_key_a | input | 1 | One-cycle pulse of clear command A |
| clr_key_b | input | 1 | One-cycle pulse of clear command B |
| halt_cmd | input | 1 | One-cycle pulse entering power-down |
| wdt_reset | output | 1 | One-cycle reset request on time-out in normal running |
| wake_req | output | 1 | One-cycle wake request on time-out in power-down |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |

## Verification
The embedded assertions check the following on every cycle:
- the two time-out outputs never fire together;
- an expiry always leaves the counter at zero and the time-out flag set;
- a halt always leaves power-down flagged with time-out cleared;
- a completed clear without a halt clears both flags;
- a repeated single key never completes a pair.

Only the bench scenarios can show the following:
- the exact period for every tap, counted edge by edge;
- that a repeated key really leaves the running count untouched;
- that keys are ignored while halted;
- how coincident events on the expiry edge are resolved.

// File: rtl/wdt_pkg.sv
// Shared types for the two-key watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdt_pkg;
    // Which clear key arrived last without its partner.
    typedef enum logic [1:0] {
        KEY_NONE = 2'd0,
        KEY_A    = 2'd1,
        KEY_B    = 2'd2
    } key_e;
endpackage

// File: rtl/wdt_key_seq.sv
// Clear-key sequencer: decides when the clear commands form a valid clear.
// Pair mode needs key A then B or B then A; single mode takes either key.
// Assumes: keys are one-cycle pulses, already gated off during power-down.
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic single_i,
    input  logic key_a_i,
    input  logic key_b_i,
    input  logic flush_i,
    output logic complete_o
);
    key_e last_q;
    key_e last_d;

    // Combine the incoming keys with the remembered one.
    always_comb begin
        if (single_i) begin
            complete_o = key_a_i | key_b_i;
        end else begin
            complete_o = (key_a_i & key_b_i)
                       | (key_a_i & (last_q == KEY_B))
                       | (key_b_i & (last_q == KEY_A));
        end
        if (flush_i || complete_o) last_d = KEY_NONE;
        else if (key_a_i)          last_d = KEY_A;
        else if (key_b_i)          last_d = KEY_B;
        else                       last_d = last_q;
    end

    // Hold the key history.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= KEY_NONE;
        else        last_q <= last_d;
    end

    // R4: a repeated key never completes a pair.
    assert_repeat_a_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_i && key_a_i && !key_b_i && last_q == KEY_A) |-> !complete_o);
    assert_repeat_b_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_i && key_b_i && !key_a_i && last_q == KEY_B) |-> !complete_o);
endmodule

// File: rtl/wdt_timebase.sv
// Watchdog time base: counts clock edges and flags expiry at the tap period.
// Assumes: tap_sel is stable while running; a smaller tap expires at once.
module wdt_timebase #(
    parameter int BASE_LOG = 12,
    parameter int TAPS     = 4,
    localparam int TSW     = (TAPS > 1) ? $clog2(TAPS) : 1,
    localparam int CW      = BASE_LOG + TAPS - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TSW-1:0] tap_sel,
    input  logic           restart_i,
    output logic           expire_o
);
    logic [CW-1:0] cnt_q;
    logic [CW:0]   lim_w;
    int unsigned   tap_eff;
    logic          hit;

    // Last count value of the selected period.
    always_comb begin
        tap_eff = (int'(tap_sel) >= TAPS) ? TAPS - 1 : int'(tap_sel);
        lim_w   = ({{CW{1'b0}}, 1'b1} << (BASE_LOG + tap_eff)) - {{CW{1'b0}}, 1'b1};
        hit     = ({1'b0, cnt_q} >= lim_w);
        expire_o = hit & ~restart_i;
    end

    // Count up; restart on command or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || hit) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end

    // R2: an expiry always restarts the count.
    assert_expire_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> cnt_q == '0);
    // R10: a restart request masks expiry.
    assert_restart_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |-> !expire_o);
endmodule

// File: rtl/wdt_status.sv
// Status and request logic: TO/PD flags, power-down state, output pulses.
// Priority on one edge: halt, then completed clear, then expiry.
// Assumes: expire_i is already masked by halt and clear.
module wdt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_i,
    input  logic clear_i,
    input  logic expire_i,
    output logic asleep_o,
    output logic to_o,
    output logic pd_o,
    output logic rst_req_o,
    output logic wake_o
);
    // Update flags, sleep state and one-cycle requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_o      <= 1'b0;
            pd_o      <= 1'b0;
            asleep_o  <= 1'b0;
            rst_req_o <= 1'b0;
            wake_o    <= 1'b0;
        end else begin
            rst_req_o <= expire_i & ~asleep_o;
            wake_o    <= expire_i & asleep_o;
            if (halt_i) begin
                pd_o     <= 1'b1;
                to_o     <= 1'b0;
                asleep_o <= 1'b1;
            end else if (clear_i) begin
                pd_o <= 1'b0;
                to_o <= 1'b0;
            end else if (expire_i) begin
                to_o     <= 1'b1;
                asleep_o <= 1'b0;
            end
        end
    end

    assert_one_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_o && wake_o));
    assert_expire_sets_to_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> to_o);
    assert_halt_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (pd_o && !to_o && asleep_o));
    assert_clear_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !halt_i) |=> (!pd_o && !to_o));
    assert_wake_keeps_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && asleep_o) |=> (pd_o && wake_o && !asleep_o));
endmodule

// File: rtl/wdt_two_key.sv
// Two-key watchdog top: ties key sequencer, time base and status together.
// Keys are ignored in power-down; a halt or a timeout flushes a half-entered pair.
// Assumes: all command inputs are synchronous one-cycle pulses.
module wdt_two_key #(
    parameter int BASE_LOG = 12,
    parameter int TAPS     = 4,
    localparam int TSW     = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TSW-1:0] tap_sel,
    input  logic           single_clr_en,
    input  logic           clr_key_a,
    input  logic           clr_key_b,
    input  logic           halt_cmd,
    output logic           wdt_reset,
    output logic           wake_req,
    output logic           to_flag,
    output logic           pd_flag
);
    logic asleep;
    logic key_a_g;
    logic key_b_g;
    logic clear_ok;
    logic expire;
    logic restart;

    // Gate keys in power-down and form the restart request.
    always_comb begin
        key_a_g = clr_key_a & ~asleep;
        key_b_g = clr_key_b & ~asleep;
        restart = halt_cmd | clear_ok;
    end

    wdt_key_seq u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .single_i   (single_clr_en),
        .key_a_i    (key_a_g),
        .key_b_i    (key_b_g),
        .flush_i    (halt_cmd | expire),
        .complete_o (clear_ok)
    );

    wdt_timebase #(.BASE_LOG(BASE_LOG), .TAPS(TAPS)) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .tap_sel   (tap_sel),
        .restart_i (restart),
        .expire_o  (expire)
    );

    wdt_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_i    (halt_cmd),
        .clear_i   (clear_ok),
        .expire_i  (expire),
        .asleep_o  (asleep),
        .to_o      (to_flag),
        .pd_o      (pd_flag),
        .rst_req_o (wdt_reset),
        .wake_o    (wake_req)
    );

    // R9: keys in power-down never complete a clear.
    assert_sleep_keys_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !halt_cmd) |-> !clear_ok);
endmodule

// File: tb/tb_wdt_two_key.sv
// Bench for the two-key watchdog, small configuration (periods 16..128).
module tb_wdt_two_key;
    localparam int BL = 4;
    localparam int NT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tap_sel = 2'd0;
    logic       single_clr_en = 1'b0;
    logic       clr_key_a = 1'b0;
    logic       clr_key_b = 1'b0;
    logic       halt_cmd = 1'b0;
    logic       wdt_reset, wake_req, to_flag, pd_flag;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_two_key #(.BASE_LOG(BL), .TAPS(NT)) dut (
        .clk(clk), .rst_n(rst_n), .tap_sel(tap_sel), .single_clr_en(single_clr_en),
        .clr_key_a(clr_key_a), .clr_key_b(clr_key_b), .halt_cmd(halt_cmd),
        .wdt_reset(wdt_reset), .wake_req(wake_req), .to_flag(to_flag), .pd_flag(pd_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Each of these tasks consumes exactly one rising edge per step, ending at a negedge.
    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input logic a, input logic b, input logic h);
        clr_key_a = a; clr_key_b = b; halt_cmd = h;
        @(negedge clk);
        clr_key_a = 1'b0; clr_key_b = 1'b0; halt_cmd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expect the chosen request (0 reset, 1 wake) exactly on the n-th edge from now.
    task automatic expect_out(input string req, input int n, input int which);
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            #1;
            chk(req, int'(wdt_reset), (which == 0 && i == n) ? 1 : 0);
            chk(req, int'(wake_req),  (which == 1 && i == n) ? 1 : 0);
        end
        @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 to", int'(to_flag), 0);
        chk("R1 pd", int'(pd_flag), 0);
        chk("R1 rst", int'(wdt_reset), 0);
        chk("R1 wake", int'(wake_req), 0);

        // R2 / R7: period sweep over all taps, twice each
        for (int t = 0; t < NT; t++) begin
            tap_sel = 2'(t);
            do_reset();
            expect_out("R2 period", 1 << (BL + t), 0);
            chk("R7 to set", int'(to_flag), 1);
            chk("R7 pd kept", int'(pd_flag), 0);
            expect_out("R7 restart", 1 << (BL + t), 0);
        end
        tap_sel = 2'd0;

        // R3: B then A after a timeout clears flags and restarts
        do_reset();
        expect_out("R3 first", 16, 0);
        idle(2);
        pulse(0, 1, 0);
        pulse(1, 0, 0);
        chk("R3 to cleared", int'(to_flag), 0);
        expect_out("R3 B-A restart", 16, 0);
        idle(5);
        pulse(1, 0, 0);
        pulse(0, 1, 0);
        expect_out("R3 A-B restart", 16, 0);

        // R4: A,A does not restart
        do_reset();
        pulse(1, 0, 0);
        pulse(1, 0, 0);
        expect_out("R4 A-A inert", 14, 0);
        pulse(0, 1, 0);
        pulse(0, 1, 0);
        chk("R4 to kept", int'(to_flag), 1);
        expect_out("R4 B-B inert", 14, 0);
        pulse(1, 0, 0);
        pulse(1, 0, 0);
        pulse(0, 1, 0);
        chk("R4 A-A-B clears", int'(to_flag), 0);
        expect_out("R4 A-A-B restart", 16, 0);

        // R5: single mode
        single_clr_en = 1'b1;
        do_reset();
        idle(3);
        pulse(1, 0, 0);
        expect_out("R5 single A", 16, 0);
        pulse(0, 1, 0);
        chk("R5 single B clears", int'(to_flag), 0);
        expect_out("R5 single B", 16, 0);
        single_clr_en = 1'b0;

        // R6 / R8: halt then wake
        do_reset();
        expect_out("R6 pre", 16, 0);
        idle(4);
        pulse(1, 0, 0);
        pulse(0, 0, 1);
        chk("R6 pd", int'(pd_flag), 1);
        chk("R6 to", int'(to_flag), 0);
        pulse(0, 1, 0);
        expect_out("R8 wake", 15, 1);
        chk("R8 to", int'(to_flag), 1);
        chk("R8 pd", int'(pd_flag), 1);
        expect_out("R8 awake again", 16, 0);

        // R9: keys ignored while halted
        do_reset();
        pulse(0, 0, 1);
        pulse(1, 0, 0);
        pulse(0, 1, 0);
        chk("R9 pd kept", int'(pd_flag), 1);
        expect_out("R9 keys ignored", 14, 1);
        do_reset();
        chk("R1 pd cleared by reset", int'(pd_flag), 0);

        // R10: clear on the expiry edge
        do_reset();
        idle(14);
        pulse(1, 0, 0);
        pulse(0, 1, 0);
        #1;
        chk("R10 clear beats expiry", int'(wdt_reset), 0);
        chk("R10 to", int'(to_flag), 0);
        @(negedge clk);
        expect_out("R10 after clash", 15, 0);
        // R10: halt beats a simultaneous clear
        do_reset();
        pulse(1, 1, 1);
        chk("R10 halt wins", int'(pd_flag), 1);
        // R10: both keys at once complete a pair
        do_reset();
        idle(3);
        pulse(1, 1, 0);
        expect_out("R10 both keys", 16, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule